// File: doc/BRIEF.md
# HDMI Signature Detector for Display Extension Blocks

This block watches a 128-byte display-identification extension block as it streams past, one byte per accepted cycle in ascending index order, and decides whether the block is a consumer-electronics timing extension that carries a vendor-specific data block with the 24-bit HDMI registration identifier. When the identifier is present, the block also reports the basic-audio capability bit taken from the extension header. The result lets the surrounding display path choose between an HDMI link with audio and a plain DVI-style link.

A one-cycle start pulse arms the detector and clears its results. The bytes that follow are parsed on the fly. The header supplies the tag byte, the end offset of the data-block collection and the audio flag. The detector then follows the chain of tag/length headers from index 4. It checks each header against the end offset so that a corrupt length cannot run past the collection. The walk stops as soon as the outcome is known: at a bad tag, a short collection, a length overrun, the end of the walk, or the first match. In that case a single `done_o` pulse marks the result as valid, and any bytes still arriving are ignored.

Top module: `edid_hdmi_sig_detect`

## Requirements
- R1: After reset, and in the cycle after a `start_i` pulse is captured, `done_o`, `hdmi_found_o` and `audio_ok_o` are all 0. A new `start_i` abandons a walk that is still in progress without producing a `done_o`.
- R2: If byte index 0 is not 0x02, the result is not-found, and `done_o` pulses in the cycle after byte 0 is accepted.
- R3: Byte index 2 is the end offset of the collection. If it is 4 or less, the result is not-found, and `done_o` pulses in the cycle after byte 2.
- R4: The first header sits at index 4. A header byte holds the tag in bits 7:5 and the payload length in bits 4:0. A header that does not match moves the next header position to its own index plus one plus the length.
- R5: If a header's index plus its length plus one exceeds the end offset, the result is not-found, decided at that header byte.
- R6: When the stream reaches the next header position and that position is at or above the end offset, the result is not-found, decided at that byte.
- R7: A header with tag 3 and length of at least 5 whose next three bytes are 0x03, 0x0C, 0x00 in that order gives found, with `done_o` in the cycle after the third of those bytes. A different order, or a length below 5, is not a match.
- R8: When found, `audio_ok_o` equals bit 6 of byte index 3. When not found, it is 0.
- R9: Exactly one `done_o` pulse follows each completed start. After it, further bytes are ignored, and the outputs hold until the next start.
- R10: If no decision has been reached by index 127, the result is not-found, decided at byte 127. This covers headers and payloads that reach past the block.
- R11: Cycles with `byte_valid_i` low consume no byte and do not change the index count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Arms a new block walk and clears the results |
| byte_valid_i | input | 1 | `byte_i` carries the next block byte |
| byte_i | input | 8 | Block byte, index order from 0 |
| done_o | output | 1 | One-cycle pulse: the results are valid |
| hdmi_found_o | output | 1 | HDMI registration identifier found |
| audio_ok_o | output | 1 | Basic audio supported (only when found) |

## Verification
A wrong internal state shows up mainly as timing. A next-header position that is off by one, or a stale candidate flag, moves the `done_o` pulse to the wrong byte or flips the result. The bench therefore compares the exact byte index at which each decision lands against an independent walk of the same block, and it does so in the cycle right after that byte. A decision that fires late or more than once appears either as an unexpected pulse or as a change in the outputs during the hold period, and the bench checks for that on every cycle.

// File: rtl/edid_sig_pkg.sv
package edid_sig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } scan_st_e;
endpackage

// File: rtl/edid_hdr_capture.sv
// Captures the extension header fields and flags header-level rejections.
module edid_hdr_capture #(
  parameter int IDX_W    = 7,
  parameter int EXT_CODE = 8'h02,
  parameter int TAG_IDX  = 0,
  parameter int OFF_IDX  = 2,
  parameter int AUD_IDX  = 3,
  parameter int AUD_BIT  = 6,
  parameter int MIN_OFF  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  output logic [7:0]       end_off_o,
  output logic             audio_o,
  output logic             tag_bad_o,
  output logic             off_bad_o
);
  logic [7:0] end_off_q, end_off_d;
  logic       audio_q, audio_d;
  logic       at_tag, at_off, at_aud;

  assign at_tag = take_i && (idx_i == IDX_W'(TAG_IDX));
  assign at_off = take_i && (idx_i == IDX_W'(OFF_IDX));
  assign at_aud = take_i && (idx_i == IDX_W'(AUD_IDX));

  always_comb begin
    end_off_d = end_off_q;
    audio_d   = audio_q;
    if (clr_i) begin
      end_off_d = '0;
      audio_d   = 1'b0;
    end else begin
      if (at_off) end_off_d = byte_i;
      if (at_aud) audio_d   = byte_i[AUD_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_off_q <= '0;
      audio_q   <= 1'b0;
    end else begin
      end_off_q <= end_off_d;
      audio_q   <= audio_d;
    end
  end

  assign tag_bad_o = at_tag && (byte_i != 8'(EXT_CODE));
  assign off_bad_o = at_off && (byte_i <= 8'(MIN_OFF));
  assign end_off_o = end_off_q;
  assign audio_o   = audio_q;

  AST_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !at_off) |=> $stable(end_off_q)) else $error("end offset moved"); // R3
endmodule

// File: rtl/edid_oui_match.sv
// Compares one payload byte with the expected registration-identifier byte.
module edid_oui_match #(
  parameter int                    OUI_LEN = 3,
  parameter logic [8*OUI_LEN-1:0]  OUI_SEQ = 24'h030C00,
  parameter int                    CNT_W   = 2
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [7:0]       byte_i,
  output logic             eq_o
);
  localparam int SLOTS = 1 << CNT_W;
  logic [7:0] seq [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_seq
    if (g < OUI_LEN) begin : g_used
      assign seq[g] = OUI_SEQ[8*(OUI_LEN-g)-1 -: 8];
    end else begin : g_pad
      assign seq[g] = 8'h00;
    end
  end

  assign eq_o = (int'(cnt_i) < OUI_LEN) && (byte_i == seq[cnt_i]);
endmodule

// File: rtl/edid_blk_walker.sv
// Follows the tag/length header chain and tracks the candidate payload.
module edid_blk_walker #(
  parameter int                   IDX_W      = 7,
  parameter int                   DATA_START = 4,
  parameter int                   MATCH_TAG  = 3,
  parameter int                   MIN_LEN    = 5,
  parameter int                   OUI_LEN    = 3,
  parameter logic [8*OUI_LEN-1:0] OUI_SEQ    = 24'h030C00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  input  logic [7:0]       end_off_i,
  output logic             walk_end_o,
  output logic             overrun_o,
  output logic             hit_o
);
  localparam int POS_W = ((IDX_W + 2) > 9) ? (IDX_W + 2) : 9;
  localparam int CNT_W = $clog2(OUI_LEN + 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             cand_q, cand_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic [POS_W-1:0] idx_ext, end_ext, nxt;
  logic [4:0]       len;
  logic [2:0]       tag;
  logic             at_hdr, walk_end, overrun, is_cand, in_pay, oui_eq, last_pay;

  assign idx_ext  = POS_W'(idx_i);
  assign end_ext  = POS_W'(end_off_i);
  assign len      = byte_i[4:0];
  assign tag      = byte_i[7:5];
  assign nxt      = idx_ext + POS_W'(len) + POS_W'(1);
  assign at_hdr   = take_i && (idx_ext == pos_q);
  assign walk_end = at_hdr && (pos_q >= end_ext);
  assign overrun  = at_hdr && !walk_end && (nxt > end_ext);
  assign is_cand  = (tag == 3'(MATCH_TAG)) && (len >= 5'(MIN_LEN));
  assign in_pay   = take_i && cand_q && !at_hdr;
  assign last_pay = (cnt_q == CNT_W'(OUI_LEN - 1));

  edid_oui_match #(
    .OUI_LEN (OUI_LEN),
    .OUI_SEQ (OUI_SEQ),
    .CNT_W   (CNT_W)
  ) u_oui (
    .cnt_i  (cnt_q),
    .byte_i (byte_i),
    .eq_o   (oui_eq)
  );

  always_comb begin
    pos_d  = pos_q;
    cand_d = cand_q;
    cnt_d  = cnt_q;
    if (clr_i) begin
      pos_d  = POS_W'(DATA_START);
      cand_d = 1'b0;
      cnt_d  = '0;
    end else if (at_hdr && !walk_end && !overrun) begin
      pos_d  = nxt;
      cand_d = is_cand;
      cnt_d  = '0;
    end else if (in_pay) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (!oui_eq || last_pay) cand_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= POS_W'(DATA_START);
      cand_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pos_q  <= pos_d;
      cand_q <= cand_d;
      cnt_q  <= cnt_d;
    end
  end

  assign walk_end_o = walk_end;
  assign overrun_o  = overrun;
  assign hit_o      = in_pay && oui_eq && last_pay;

  AST_POS_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && at_hdr && !walk_end && !overrun) |=> (pos_q > $past(pos_q))) else $error("header position did not advance"); // R4
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cand_q |-> (int'(cnt_q) < OUI_LEN)) else $error("payload counter out of range"); // R7
endmodule

// File: rtl/edid_hdmi_sig_detect.sv
module edid_hdmi_sig_detect
  import edid_sig_pkg::*;
#(
  parameter int                   BLOCK_BYTES = 128,
  parameter int                   DATA_START  = 4,
  parameter int                   MATCH_TAG   = 3,
  parameter int                   MIN_LEN     = 5,
  parameter int                   OUI_LEN     = 3,
  parameter logic [8*OUI_LEN-1:0] OUI_SEQ     = 24'h030C00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  output logic       done_o,
  output logic       hdmi_found_o,
  output logic       audio_ok_o
);
  localparam int IDX_W    = $clog2(BLOCK_BYTES);
  localparam int LAST_IDX = BLOCK_BYTES - 1;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  scan_st_e         state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             found_q, found_d, aud_q, aud_d, done_q, done_d;

  logic       accept, walk_take;
  logic [7:0] end_off;
  logic       audio_bit, tag_bad, off_bad, walk_end, overrun, hit;
  logic       at_last, no_sig, decide;

  assign accept    = byte_valid_i && (state_q == ST_SCAN) && !start_i;
  assign walk_take = accept && (idx_q >= IDX_W'(DATA_START));
  assign at_last   = accept && (idx_q == IDX_W'(LAST_IDX));

  edid_hdr_capture #(
    .IDX_W (IDX_W)
  ) u_hdr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (start_i),
    .take_i    (accept),
    .idx_i     (idx_q),
    .byte_i    (byte_i),
    .end_off_o (end_off),
    .audio_o   (audio_bit),
    .tag_bad_o (tag_bad),
    .off_bad_o (off_bad)
  );

  edid_blk_walker #(
    .IDX_W      (IDX_W),
    .DATA_START (DATA_START),
    .MATCH_TAG  (MATCH_TAG),
    .MIN_LEN    (MIN_LEN),
    .OUI_LEN    (OUI_LEN),
    .OUI_SEQ    (OUI_SEQ)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr_i      (start_i),
    .take_i     (walk_take),
    .idx_i      (idx_q),
    .byte_i     (byte_i),
    .end_off_i  (end_off),
    .walk_end_o (walk_end),
    .overrun_o  (overrun),
    .hit_o      (hit)
  );

  assign no_sig = tag_bad || off_bad || walk_end || overrun || (at_last && !hit);
  assign decide = hit || no_sig;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    found_d = found_q;
    aud_d   = aud_q;
    done_d  = 1'b0;
    if (start_i) begin
      state_d = ST_SCAN;
      idx_d   = '0;
      found_d = 1'b0;
      aud_d   = 1'b0;
    end else if (state_q == ST_SCAN && accept) begin
      idx_d = idx_q + IDX_W'(1);
      if (decide) begin
        state_d = ST_HOLD;
        done_d  = 1'b1;
        found_d = hit;
        aud_d   = hit && audio_bit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      found_q <= 1'b0;
      aud_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      found_q <= found_d;
      aud_q   <= aud_d;
      done_q  <= done_d;
    end
  end

  assign done_o       = done_q;
  assign hdmi_found_o = found_q;
  assign audio_ok_o   = aud_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_i |=> (!done_o && !hdmi_found_o && !audio_ok_o)) else $error("start did not clear"); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R9
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_HOLD && !start_i) |=> ($stable(hdmi_found_o) && $stable(audio_ok_o) && !done_o)) else $error("result changed in hold"); // R9
  AST_FOUND_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(hdmi_found_o) |-> done_o) else $error("found rose without done"); // R7
  AST_AUDIO_NEEDS_FOUND: assert property (@(posedge clk) disable iff (!rst_int_n)
    audio_ok_o |-> hdmi_found_o) else $error("audio without found"); // R8
endmodule

// File: tb/edid_hdmi_sig_detect_tb_top.sv
module edid_hdmi_sig_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       done_o, hdmi_found_o, audio_ok_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  edid_hdmi_sig_detect dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .done_o       (done_o),
    .hdmi_found_o (hdmi_found_o),
    .audio_ok_o   (audio_ok_o)
  );

  typedef struct packed { logic f; logic a; logic [7:0] di; } exp_t;

  int    n_checks = 0;
  int    n_fail = 0;
  int    done_cnt = 0;
  int    exp_dones = 0;
  bit    finished = 0;
  logic [7:0] blk [NB];
  exp_t  exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent walk of the block following the requirement rules.
  task automatic model(output logic f, output logic a, output int di);
    int p, off, len, tag;
    f = 1'b0; a = 1'b0; di = 0;
    if (blk[0] != 8'h02) begin di = 0; return; end
    off = int'(blk[2]);
    if (off <= 4) begin di = 2; return; end
    p = 4;
    for (int guard = 0; guard < 300; guard++) begin
      if (p > NB - 1) begin di = NB - 1; return; end
      if (p >= off) begin di = p; return; end
      len = int'(blk[p][4:0]);
      tag = int'(blk[p][7:5]);
      if (p + len + 1 > off) begin di = p; return; end
      if (tag == 3 && len >= 5) begin
        if (p + 3 > NB - 1) begin di = NB - 1; return; end
        if (blk[p+1] == 8'h03 && blk[p+2] == 8'h0C && blk[p+3] == 8'h00) begin
          f = 1'b1; a = blk[3][6]; di = p + 3; return;
        end
      end
      p = p + 1 + len;
    end
  endtask

  task automatic clear_blk();
    for (int k = 0; k < NB; k++) blk[k] = 8'h00;
  endtask

  task automatic run_block(input string t, input int gap, input int nfeed, input bit expect_done);
    logic f, a;
    int   di;
    if (expect_done) begin
      model(f, a, di);
      exp_q.push_back({f, a, 8'(di)});
      tag_q.push_back(t);
      exp_dones++;
    end
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    for (int k = 0; k < nfeed; k++) begin
      if (gap != 0 && (k % gap) == 1) begin
        byte_valid_i = 1'b0;
        @(posedge clk); #1;
      end
      byte_valid_i = 1'b1;
      byte_i = blk[k];
      @(posedge clk); #1;
    end
    byte_valid_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  // Monitor / scoreboard
  int   seen_cnt = 0;
  bit   held = 0;
  bit   start_pend = 0;
  logic held_f = 1'b0;
  logic held_a = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (start_pend) begin
        chk(!hdmi_found_o && !audio_ok_o && !done_o, "R1 cleared after start",
            int'({done_o, hdmi_found_o, audio_ok_o}), 0);
        start_pend = 0;
      end
      if (done_o) begin
        done_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(hdmi_found_o == e.f, {t, " found"}, int'(hdmi_found_o), int'(e.f));
          chk(audio_ok_o == e.a, {t, " audio R8"}, int'(audio_ok_o), int'(e.a));
          chk((seen_cnt - 1) == int'(e.di), {t, " decide index"}, seen_cnt - 1, int'(e.di));
        end
        held = 1; held_f = hdmi_found_o; held_a = audio_ok_o;
      end else if (held) begin
        chk(hdmi_found_o == held_f && audio_ok_o == held_a, "R9 outputs hold",
            int'({hdmi_found_o, audio_ok_o}), int'({held_f, held_a}));
      end
      if (start_i) begin
        seen_cnt = 0; held = 0; start_pend = 1;
      end else if (byte_valid_i) begin
        seen_cnt++;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R9 actual=timeout expected=finish");
      finish_run();
    end
  end

  task automatic blk_match_first(input logic [7:0] aud);
    clear_blk();
    blk[0] = 8'h02; blk[2] = 8'd40; blk[3] = aud;
    blk[4] = 8'h65; blk[5] = 8'h03; blk[6] = 8'h0C; blk[7] = 8'h00;
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!done_o && !hdmi_found_o && !audio_ok_o, "R1 reset state",
        int'({done_o, hdmi_found_o, audio_ok_o}), 0);
    @(posedge clk); #1;

    // R2: wrong extension code
    clear_blk(); blk[0] = 8'h01; blk[2] = 8'd40;
    run_block("R2 bad code", 0, NB, 1'b1);

    // R3: end offset of 4
    clear_blk(); blk[0] = 8'h02; blk[2] = 8'd4;
    run_block("R3 short offset", 0, NB, 1'b1);

    // R7 R8 R4: match in the first data block, audio set
    blk_match_first(8'h40);
    run_block("R7 first block match", 0, NB, 1'b1);

    // R4: skip one non-matching block, match the second, audio clear
    clear_blk();
    blk[0] = 8'h02; blk[2] = 8'd40; blk[3] = 8'h00;
    blk[4] = 8'h43; blk[5] = 8'h03; blk[6] = 8'h0C; blk[7] = 8'h00;
    blk[8] = 8'h66; blk[9] = 8'h03; blk[10] = 8'h0C; blk[11] = 8'h00;
    run_block("R4 second block match", 0, NB, 1'b1);

    // R6 R7: tag 3 but length 4, then walk to end offset
    clear_blk();
    blk[0] = 8'h02; blk[2] = 8'd20; blk[3] = 8'h40;
    blk[4] = 8'h64; blk[5] = 8'h03; blk[6] = 8'h0C; blk[7] = 8'h00;
    run_block("R6 short length walk end", 0, NB, 1'b1);

    // R7: identifier bytes in the wrong order
    clear_blk();
    blk[0] = 8'h02; blk[2] = 8'd30; blk[3] = 8'h40;
    blk[4] = 8'h65; blk[5] = 8'h0C; blk[6] = 8'h03; blk[7] = 8'h00;
    run_block("R7 wrong order", 0, NB, 1'b1);

    // R5: length runs past end offset
    clear_blk();
    blk[0] = 8'h02; blk[2] = 8'd10;
    blk[4] = 8'h2A;
    run_block("R5 overrun", 0, NB, 1'b1);

    // R10: chain reaches beyond the block
    clear_blk();
    blk[0] = 8'h02; blk[2] = 8'd200; blk[3] = 8'h40;
    blk[4] = 8'h3F; blk[36] = 8'h3F; blk[68] = 8'h3F; blk[100] = 8'h3F;
    run_block("R10 past block end", 0, NB, 1'b1);

    // R7 R10: match ending exactly on the last byte
    clear_blk();
    blk[0] = 8'h02; blk[2] = 8'd200; blk[3] = 8'h40;
    blk[4] = 8'h3F; blk[36] = 8'h3F; blk[68] = 8'h3F; blk[100] = 8'h37;
    blk[124] = 8'h65; blk[125] = 8'h03; blk[126] = 8'h0C; blk[127] = 8'h00;
    run_block("R7 match at last byte", 0, NB, 1'b1);

    // R11: same match with idle gaps in the stream
    clear_blk();
    blk[0] = 8'h02; blk[2] = 8'd40; blk[3] = 8'h40;
    blk[4] = 8'h43; blk[8] = 8'h65; blk[9] = 8'h03; blk[10] = 8'h0C; blk[11] = 8'h00;
    run_block("R11 gapped stream", 2, NB, 1'b1);

    // R1: abandoned walk produces no done, then a fresh block
    blk_match_first(8'h40);
    run_block("R1 abandoned", 0, 4, 1'b0);

    // R9: match followed by a second match that must be ignored
    blk_match_first(8'h40);
    blk[12] = 8'h65; blk[13] = 8'h03; blk[14] = 8'h0C; blk[15] = 8'h00;
    run_block("R9 early exit", 0, NB, 1'b1);

    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R9 no pending results", exp_q.size(), 0);
    chk(done_cnt == exp_dones, "R9 one done per block", done_cnt, exp_dones);
    finish_run();
  end
endmodule